// File: doc/BRIEF.md
# Core Sleep and Power-Gating Sequencer

This block steps one processor core into a low-power state and back out again. Software first sets an arm bit. The core then executes its wait-for-interrupt and raises a standby flag. At that point the sequencer stops the core and bus clocks. Depending on two further configuration bits, it then does one of three things:

- It stays in plain clock-gated sleep.
- It removes core power.
- It enters deep sleep. The memory controller is first told to enter self-refresh. Once self-refresh is acknowledged, the PLLs and every module clock stop, except those named in a keep-alive mask.

A wake interrupt reverses the chosen path. Leaving deep sleep, the sequencer turns the PLLs and the memory clock on first. It waits for the memory DLL to lock before the core and the other module clocks run again. If power was removed, the core's reset is held for a fixed number of cycles after power returns, so the core restarts from address 0.

The states are:

| State | Meaning |
| --- | --- |
| RUN | Normal operation |
| ARMED | Waiting for standby |
| GATE | Clock-gated sleep |
| PWROFF | Core power removed |
| RSTHOLD | Power back, reset held |
| SRREQ | Self-refresh requested, waiting for acknowledge |
| DEEP | PLLs stopped |
| MEMUP | Memory clock back, waiting for DLL lock |

The transitions are:

| From | To | Condition |
| --- | --- | --- |
| RUN | ARMED | Arm set |
| ARMED | RUN | Wake, or arm cleared (abort) |
| ARMED | GATE | Standby |
| GATE | RUN | Wake |
| GATE | SRREQ | Deep bit set |
| GATE | PWROFF | Power-down bit set and deep bit clear |
| PWROFF | RSTHOLD | Wake |
| RSTHOLD | RUN | Hold count done |
| SRREQ | DEEP | Self-refresh acknowledge |
| DEEP | MEMUP | Wake |
| MEMUP | RUN | DLL lock, power was not removed |
| MEMUP | RSTHOLD | DLL lock, power was removed |

Top module: `cpu_sleep_seq`

## Requirements
- R1: While reset is asserted and directly after it, every clock enable and the PLL enable are 1, core power is on, core reset is released (`core_rst_n_o`=1), the self-refresh request is 0 and status bits 2:1 are 0.
- R2: Status bit 0 always equals the arm input. Bit 1 is the standby flag and bit 2 is the sleep flag.
- R3: When the sequencer is armed and standby is seen, core and bus clocks stop one cycle later and status bits 1 and 2 are set. PLL, memory and module clocks stay on.
- R4: A wake during clock-gated sleep turns the core and bus clocks back on at the next cycle and clears status bits 1 and 2.
- R5: If a wake arrives while armed, or the arm bit is cleared before standby, the sequencer returns to run. No clock is ever gated. Wake wins over a simultaneous standby.
- R6: In sleep with the power-down bit set and the deep bit clear, core power is removed one cycle later. Core reset is low whenever core power is off.
- R7: A wake after power removal restores power and the core and bus clocks at once. Core reset is held low for exactly RST_CYC cycles with power on, then released.
- R8: In sleep with the deep bit set (this wins over the power-down bit), self-refresh is requested. PLLs and the memory clock stay on until the acknowledge arrives. A wake before the acknowledge is deferred.
- R9: In deep sleep the PLL enable and memory clock are 0 and the module clock enables equal the keep-alive mask. Outside deep sleep and its exit state, all module clocks are on.
- R10: A wake in deep sleep turns the PLLs and memory clock on and drops the self-refresh request. The core clock stays off and module clocks stay at the mask until the DLL reports lock; then the sequencer returns to run.
- R11: In deep sleep entered with the power-down bit set, core power is off. On exit, power returns only after DLL lock, followed by the R7 reset hold.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_arm_i | input | 1 | Software bit that arms the sleep sequence |
| cfg_pgate_i | input | 1 | Software bit requesting core power removal |
| cfg_deep_i | input | 1 | Software bit selecting deep sleep |
| keep_mask_i | input | NCLK | Module clocks that stay on in deep sleep |
| core_stby_i | input | 1 | Core standby-for-interrupt flag |
| wake_irq_i | input | 1 | Wake interrupt (level) |
| mem_sr_ack_i | input | 1 | Memory self-refresh status |
| dll_lock_i | input | 1 | Memory DLL lock |
| core_clk_en_o | output | 1 | Core clock enable |
| bus_clk_en_o | output | 1 | Bus clock enable |
| core_pwr_on_o | output | 1 | Core power switch |
| core_rst_n_o | output | 1 | Core reset, active low |
| pll_en_o | output | 1 | PLL enable |
| mem_clk_en_o | output | 1 | Memory clock enable |
| mod_clk_en_o | output | NCLK | Module clock enables |
| mem_sr_req_o | output | 1 | Self-refresh request |
| stat_o | output | 3 | Status: bit0 arm, bit1 standby, bit2 sleep |

## Verification
The bench builds the block with its defaults: four module clocks (NCLK=4) and a 16-cycle reset hold (RST_CYC=16). The keep-alive mask is held at 0101, so one deep-sleep check separates kept clocks from stopped ones. The 16-cycle hold is short enough for the bench to count every held cycle after power returns. That count is made both on the plain power-down exit and on the deep-sleep exit with power removed.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [2:0] {
        S_RUN, S_ARMED, S_GATE, S_PWROFF, S_RSTHOLD, S_SRREQ, S_DEEP, S_MEMUP
    } slp_state_e;

    typedef struct packed {
        logic core_clk;
        logic bus_clk;
        logic pwr;
        logic rst_n;
        logic pll;
        logic mem_clk;
        logic sr_req;
        logic mods_all;
        logic stby_flag;
        logic sleep_flag;
    } slp_ctl_t;
endpackage

// File: rtl/slp_hold_cnt.sv
module slp_hold_cnt #(
    parameter int RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);
    localparam int CW = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign done = active && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!active)
            cnt_q <= '0;
        else if (!done)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       pgate,
    input  logic       deep,
    input  logic       stby,
    input  logic       wake,
    input  logic       sr_ack,
    input  logic       dll_lock,
    input  logic       hold_done,
    output slp_state_e state,
    output logic       pg_sel
);
    slp_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_RUN;
            pg_sel <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_GATE)
                pg_sel <= pgate;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_RUN:     if (arm) nxt = S_ARMED;
            S_ARMED: begin
                if (wake || !arm) nxt = S_RUN;
                else if (stby)    nxt = S_GATE;
            end
            S_GATE: begin
                if (wake)       nxt = S_RUN;
                else if (deep)  nxt = S_SRREQ;
                else if (pgate) nxt = S_PWROFF;
            end
            S_PWROFF:  if (wake) nxt = S_RSTHOLD;
            S_RSTHOLD: if (hold_done) nxt = S_RUN;
            S_SRREQ:   if (sr_ack) nxt = S_DEEP;
            S_DEEP:    if (wake) nxt = S_MEMUP;
            S_MEMUP:   if (dll_lock) nxt = pg_sel ? S_RSTHOLD : S_RUN;
            default:   nxt = S_RUN;
        endcase
    end
endmodule

// File: rtl/slp_out_dec.sv
module slp_out_dec
    import slp_pkg::*;
#(
    parameter int NCLK = 4
) (
    input  slp_state_e      state,
    input  logic            pg_sel,
    input  logic [NCLK-1:0] keep_mask,
    output slp_ctl_t        ctl,
    output logic [NCLK-1:0] mod_en
);
    always_comb begin
        ctl = '{core_clk: 1'b1, bus_clk: 1'b1, pwr: 1'b1, rst_n: 1'b1,
                pll: 1'b1, mem_clk: 1'b1, sr_req: 1'b0, mods_all: 1'b1,
                stby_flag: 1'b0, sleep_flag: 1'b0};
        unique case (state)
            S_RUN, S_ARMED: ;
            S_GATE: begin
                ctl.core_clk = 1'b0; ctl.bus_clk = 1'b0;
                ctl.stby_flag = 1'b1; ctl.sleep_flag = 1'b1;
            end
            S_PWROFF: begin
                ctl.core_clk = 1'b0; ctl.bus_clk = 1'b0;
                ctl.pwr = 1'b0; ctl.rst_n = 1'b0;
                ctl.stby_flag = 1'b1; ctl.sleep_flag = 1'b1;
            end
            S_RSTHOLD: begin
                ctl.rst_n = 1'b0; ctl.stby_flag = 1'b1;
            end
            S_SRREQ: begin
                ctl.core_clk = 1'b0; ctl.bus_clk = 1'b0; ctl.sr_req = 1'b1;
                ctl.stby_flag = 1'b1; ctl.sleep_flag = 1'b1;
            end
            S_DEEP: begin
                ctl.core_clk = 1'b0; ctl.bus_clk = 1'b0;
                ctl.pwr = !pg_sel; ctl.rst_n = !pg_sel;
                ctl.pll = 1'b0; ctl.mem_clk = 1'b0; ctl.sr_req = 1'b1;
                ctl.mods_all = 1'b0;
                ctl.stby_flag = 1'b1; ctl.sleep_flag = 1'b1;
            end
            S_MEMUP: begin
                ctl.core_clk = 1'b0; ctl.bus_clk = 1'b0;
                ctl.pwr = !pg_sel; ctl.rst_n = !pg_sel;
                ctl.mods_all = 1'b0; ctl.stby_flag = 1'b1;
            end
            default: ;
        endcase
    end

    for (genvar i = 0; i < NCLK; i++) begin : g_mod
        assign mod_en[i] = ctl.mods_all | keep_mask[i];
    end
endmodule

// File: rtl/cpu_sleep_seq.sv
module cpu_sleep_seq
    import slp_pkg::*;
#(
    parameter int NCLK    = 4,
    parameter int RST_CYC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_arm_i,
    input  logic            cfg_pgate_i,
    input  logic            cfg_deep_i,
    input  logic [NCLK-1:0] keep_mask_i,
    input  logic            core_stby_i,
    input  logic            wake_irq_i,
    input  logic            mem_sr_ack_i,
    input  logic            dll_lock_i,
    output logic            core_clk_en_o,
    output logic            bus_clk_en_o,
    output logic            core_pwr_on_o,
    output logic            core_rst_n_o,
    output logic            pll_en_o,
    output logic            mem_clk_en_o,
    output logic [NCLK-1:0] mod_clk_en_o,
    output logic            mem_sr_req_o,
    output logic [2:0]      stat_o
);
    slp_state_e state;
    logic       pg_sel;
    logic       hold_done;
    slp_ctl_t   ctl;

    slp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(cfg_arm_i), .pgate(cfg_pgate_i),
        .deep(cfg_deep_i), .stby(core_stby_i), .wake(wake_irq_i),
        .sr_ack(mem_sr_ack_i), .dll_lock(dll_lock_i), .hold_done(hold_done),
        .state(state), .pg_sel(pg_sel)
    );

    slp_hold_cnt #(.RST_CYC(RST_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .active(state == S_RSTHOLD), .done(hold_done)
    );

    slp_out_dec #(.NCLK(NCLK)) u_dec (
        .state(state), .pg_sel(pg_sel), .keep_mask(keep_mask_i),
        .ctl(ctl), .mod_en(mod_clk_en_o)
    );

    assign core_clk_en_o = ctl.core_clk;
    assign bus_clk_en_o  = ctl.bus_clk;
    assign core_pwr_on_o = ctl.pwr;
    assign core_rst_n_o  = ctl.rst_n;
    assign pll_en_o      = ctl.pll;
    assign mem_clk_en_o  = ctl.mem_clk;
    assign mem_sr_req_o  = ctl.sr_req;
    assign stat_o        = {ctl.sleep_flag, ctl.stby_flag, cfg_arm_i};
endmodule

// File: rtl/slp_chk.sv
module slp_chk #(
    parameter int NCLK    = 4,
    parameter int RST_CYC = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCLK-1:0] keep_mask_i,
    input logic            core_clk_en_o,
    input logic            bus_clk_en_o,
    input logic            core_pwr_on_o,
    input logic            core_rst_n_o,
    input logic            pll_en_o,
    input logic            mem_clk_en_o,
    input logic [NCLK-1:0] mod_clk_en_o,
    input logic            mem_sr_req_o,
    input logic [2:0]      stat_o
);
    localparam int CW = $clog2(RST_CYC + 2);
    localparam logic [CW-1:0] CAP = CW'(RST_CYC + 1);
    logic [CW-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held_q <= '0;
        else if (core_pwr_on_o && !core_rst_n_o)
            held_q <= (held_q == CAP) ? held_q : held_q + 1'b1;
        else
            held_q <= '0;
    end

    // R3
    sleep_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[2] |-> (!core_clk_en_o && !bus_clk_en_o));
    // R5
    awake_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_o[1] |-> (core_clk_en_o && bus_clk_en_o && pll_en_o));
    // R6
    pwr_off_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_pwr_on_o |-> !core_rst_n_o);
    // R7
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held_q <= CW'(RST_CYC));
    // R7
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_rst_n_o) && core_pwr_on_o) |-> (held_q == CW'(RST_CYC)));
    // R8
    pll_off_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en_o |-> (mem_sr_req_o && !mem_clk_en_o));
    // R8
    sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_sr_req_o) |-> (pll_en_o && mem_clk_en_o));
    // R9
    keep_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en_o |-> (mod_clk_en_o == keep_mask_i));
    // R10
    mem_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en_o) |-> (!core_clk_en_o && !mem_sr_req_o && mem_clk_en_o));
endmodule

bind cpu_sleep_seq slp_chk #(.NCLK(NCLK), .RST_CYC(RST_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .keep_mask_i(keep_mask_i),
    .core_clk_en_o(core_clk_en_o), .bus_clk_en_o(bus_clk_en_o),
    .core_pwr_on_o(core_pwr_on_o), .core_rst_n_o(core_rst_n_o),
    .pll_en_o(pll_en_o), .mem_clk_en_o(mem_clk_en_o),
    .mod_clk_en_o(mod_clk_en_o), .mem_sr_req_o(mem_sr_req_o), .stat_o(stat_o)
);

// File: tb/sim_cpu_sleep_seq.sv
module sim_cpu_sleep_seq;
    localparam int CLK_P   = 10;
    localparam int NCLK    = 4;
    localparam int RST_CYC = 16;
    localparam logic [3:0] KEEP = 4'b0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 0, pg = 0, deep = 0, stby = 0, wake = 0, ack = 0, dll = 0;
    logic core_clk, bus_clk, pwr, crst_n, pll, mem_clk, sr_req;
    logic [NCLK-1:0] mod_en;
    logic [2:0] stat;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    cpu_sleep_seq #(.NCLK(NCLK), .RST_CYC(RST_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_arm_i(arm), .cfg_pgate_i(pg),
        .cfg_deep_i(deep), .keep_mask_i(KEEP), .core_stby_i(stby),
        .wake_irq_i(wake), .mem_sr_ack_i(ack), .dll_lock_i(dll),
        .core_clk_en_o(core_clk), .bus_clk_en_o(bus_clk),
        .core_pwr_on_o(pwr), .core_rst_n_o(crst_n), .pll_en_o(pll),
        .mem_clk_en_o(mem_clk), .mod_clk_en_o(mod_en),
        .mem_sr_req_o(sr_req), .stat_o(stat)
    );

    // bench state codes: 0 run, 1 armed, 2 gated, 3 power off, 4 reset hold,
    // 5 self-refresh wait, 6 deep, 7 memory restart
    function automatic logic [13:0] model(input logic [2:0] st, input logic p,
                                          input logic a);
        logic [6:0] c;
        logic [3:0] m;
        logic [1:0] f;
        m = 4'hF;
        case (st)
            3'd0, 3'd1: begin c = 7'b1111110; f = 2'b00; end
            3'd2:       begin c = 7'b0011110; f = 2'b11; end
            3'd3:       begin c = 7'b0000110; f = 2'b11; end
            3'd4:       begin c = 7'b1110110; f = 2'b01; end
            3'd5:       begin c = 7'b0011111; f = 2'b11; end
            3'd6:       begin c = {2'b00, !p, !p, 3'b001}; m = KEEP; f = 2'b11; end
            default:    begin c = {2'b00, !p, !p, 3'b110}; m = KEEP; f = 2'b01; end
        endcase
        return {c, m, f, a};
    endfunction

    function automatic logic [13:0] seen();
        return {core_clk, bus_clk, pwr, crst_n, pll, mem_clk, sr_req, mod_en, stat};
    endfunction

    task automatic check(input logic [13:0] act, input logic [13:0] exp,
                         input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [6:0] in);
        {arm, pg, deep, stby, wake, ack, dll} = in;
        @(posedge clk);
        #1;
    endtask

    // row: {req[3:0], arm,pg,deep,stby,wake,ack,dll, state[2:0], pg_sel}
    localparam int ROWS = 21;
    localparam logic [14:0] VEC [ROWS] = '{
        {4'd2,  7'b1000000, 3'd1, 1'b0},  // R2 arm, stat0 follows
        {4'd3,  7'b1000000, 3'd1, 1'b0},  // R3 wait standby
        {4'd3,  7'b1001000, 3'd2, 1'b0},  // R3 standby gates clocks
        {4'd3,  7'b1001000, 3'd2, 1'b0},  // R3 stays gated
        {4'd4,  7'b0000100, 3'd0, 1'b0},  // R4 wake
        {4'd4,  7'b0000000, 3'd0, 1'b0},  // R4 running
        {4'd5,  7'b1000000, 3'd1, 1'b0},  // R5 arm again
        {4'd5,  7'b1001100, 3'd0, 1'b0},  // R5 wake beats standby
        {4'd5,  7'b0000000, 3'd0, 1'b0},  // R5
        {4'd5,  7'b1000000, 3'd1, 1'b0},  // R5 arm
        {4'd5,  7'b0000000, 3'd0, 1'b0},  // R5 disarm aborts
        {4'd8,  7'b1010000, 3'd1, 1'b0},  // R8 arm with deep
        {4'd8,  7'b1011000, 3'd2, 1'b0},  // R8 standby
        {4'd8,  7'b1010000, 3'd5, 1'b0},  // R8 self-refresh requested
        {4'd8,  7'b1010100, 3'd5, 1'b0},  // R8 wake deferred
        {4'd9,  7'b1010110, 3'd6, 1'b0},  // R9 ack: PLLs off, mask
        {4'd9,  7'b0010010, 3'd6, 1'b0},  // R9 stay deep
        {4'd10, 7'b0010110, 3'd7, 1'b0},  // R10 wake: memory first
        {4'd10, 7'b0010000, 3'd7, 1'b0},  // R10 wait lock
        {4'd10, 7'b0010001, 3'd0, 1'b0},  // R10 lock: run
        {4'd10, 7'b0000000, 3'd0, 1'b0}   // R10 running
    };

    task automatic count_hold(input string tag);
        int n = 0;
        for (int i = 0; i < 4 * RST_CYC; i++) begin
            if (!(pwr && !crst_n)) break;
            n++;
            step(7'b0000000);
        end
        check(14'(n), 14'(RST_CYC), tag);
    endtask

    initial begin
        #(CLK_P * 3 + 2);
        // R1 values during reset
        check(seen(), model(3'd0, 1'b0, 1'b0), "R1 in reset");
        rst_n = 1'b1;
        step(7'b0000000);
        check(seen(), model(3'd0, 1'b0, 1'b0), "R1 after reset");

        for (int r = 0; r < ROWS; r++) begin
            step(VEC[r][10:4]);
            check(seen(), model(VEC[r][3:1], VEC[r][0], VEC[r][10]),
                  $sformatf("R%0d row %0d", VEC[r][14:11], r));
        end

        // R6 power removal
        step(7'b1100000);
        step(7'b1101000);
        step(7'b1100000);
        check(seen(), model(3'd3, 1'b0, 1'b1), "R6 power off");
        step(7'b1100000);
        check(seen(), model(3'd3, 1'b0, 1'b1), "R6 stays off");
        // R7 wake restores power, holds reset
        step(7'b0100100);
        check(seen(), model(3'd4, 1'b0, 1'b0), "R7 hold start");
        count_hold("R7 hold length");
        check(seen(), model(3'd0, 1'b0, 1'b0), "R7 released");

        // R11 deep sleep with power removal (deep wins over pgate)
        step(7'b1110000);
        step(7'b1111000);
        step(7'b1110000);
        check(seen(), model(3'd5, 1'b1, 1'b1), "R11 deep wins, power on");
        step(7'b1110010);
        check(seen(), model(3'd6, 1'b1, 1'b1), "R11 deep power off");
        step(7'b0110110);
        check(seen(), model(3'd7, 1'b1, 1'b0), "R11 memory restart unpowered");
        step(7'b0110001);
        check(seen(), model(3'd4, 1'b0, 1'b0), "R11 power after lock");
        count_hold("R11 hold length");
        check(seen(), model(3'd0, 1'b0, 1'b0), "R11 run");

        // R1 reset in the middle of sleep
        step(7'b1000000);
        step(7'b1001000);
        #2 rst_n = 1'b0;
        #1;
        {arm, stby} = 2'b00;
        #1;
        check(seen(), model(3'd0, 1'b0, 1'b0), "R1 reset during sleep");
        #(CLK_P);
        rst_n = 1'b1;
        step(7'b0000000);
        check(seen(), model(3'd0, 1'b0, 1'b0), "R1 run after reset");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule